// File: doc/BRIEF.md
# Trap and Exception Sequencer

This block sits beside the execute stage of a simple in-order pipeline and handles the two software trap instructions, break and syscall. When either trap instruction reaches execute and the pipeline is not stalled, the block takes the trap. It latches a return address into its exception PC register, kills the instruction that follows, and asks fetch to restart at a fixed exception vector, 0x03C.

The block tracks branch delay slots itself. It remembers whether the last instruction it let through execute was a jump or branch, and it keeps that instruction's address. A trap in a delay slot saves the jump's address instead of its own, so the handler can return to the jump and run it again. A stall freezes the whole sequence: no trap is taken, the exception PC holds, and the redirect is deferred until the stall drops.

Top module: `trap_seq`

## Requirements
- R1: After reset, squash_o and redirect_o are 0 and epc_o is 0.
- R2: A trap taken outside a delay slot writes the trap instruction's own address to epc_o. The new value is visible from the cycle after the trap is accepted.
- R3: A trap taken in a delay slot writes the address of the preceding jump or branch to epc_o. Delay slot here means the previous instruction accepted in execute had jump_i = 1.
- R4: squash_o is 1 in the slot after a taken trap and kills the instruction in execute during that slot, whatever it is (load, jump or trap). A killed jump does not make the next instruction a delay slot, and a killed trap is not taken.
- R5: In the slot after a taken trap, redirect_o is 1 with vector_o = 0x03C for exactly one unstalled cycle.
- R6: While stall_i is 1, no trap is taken, epc_o holds its value and redirect_o is 0. A trap waiting in execute is taken in the first cycle stall_i is 0. A pending squash is held until a cycle with stall_i = 0.
- R7: break_i and syscall_i each start the same sequence, with the same epc_o, squash and redirect behaviour.
- R8: A cycle with valid_i = 0 takes no trap and leaves the delay-slot state unchanged. A bubble between a jump and its delay-slot trap still gives the jump's address in epc_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| stall_i | input | 1 | Pipeline stall; freezes execute |
| valid_i | input | 1 | Execute holds a real instruction |
| break_i | input | 1 | Instruction in execute is break |
| syscall_i | input | 1 | Instruction in execute is syscall |
| jump_i | input | 1 | Instruction in execute is a jump or branch |
| pc_i | input | AW | Address of instruction in execute |
| squash_o | output | 1 | Kill instruction in execute this slot |
| redirect_o | output | 1 | Fetch restarts at vector_o |
| vector_o | output | AW | Exception vector address (0x03C) |
| epc_o | output | AW | Saved exception return address |

## Verification
The bench sends a trap in a delay slot that has a bubble before it. A design that cleared its delay-slot state on bubbles would save the trap's own address there instead of the jump's. It puts a jump and a second trap right behind a taken trap. A design that let the killed jump mark a delay slot, or that took the killed trap, would save a wrong epc_o or squash twice. It raises stall around a waiting trap and around the squash slot. A design that ignored stall would take the trap early, move epc_o, or send the redirect while fetch is frozen.

// File: rtl/trap_pkg.sv
package trap_pkg;
  localparam int unsigned TRAP_AW = 32;
  localparam logic [31:0] TRAP_VEC = 32'h0000_003C;
endpackage

// File: rtl/trap_ctrl.sv
module trap_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stall_i,
  input  logic valid_i,
  input  logic trap_req_i,
  output logic take_o,
  output logic pend_o
);
  logic pend_q;

  // a killed slot can never trap
  assign take_o = ~stall_i & valid_i & trap_req_i & ~pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       pend_q <= 1'b0;
    else if (!stall_i) pend_q <= take_o;
  end

  assign pend_o = pend_q;

  // R4
  one_slot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !stall_i) |=> !pend_q);
  // R6
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_i |=> $stable(pend_q));
endmodule

// File: rtl/trap_slot_track.sv
module trap_slot_track #(
  parameter int unsigned AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          adv_i,
  input  logic          kill_i,
  input  logic          take_i,
  input  logic          jump_i,
  input  logic [AW-1:0] pc_i,
  output logic          in_ds_o,
  output logic [AW-1:0] jump_pc_o
);
  logic          ds_q;
  logic [AW-1:0] jpc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ds_q  <= 1'b0;
      jpc_q <= '0;
    end else if (take_i) begin
      ds_q <= 1'b0;
    end else if (adv_i) begin
      if (kill_i) begin
        ds_q <= 1'b0;
      end else begin
        ds_q <= jump_i;
        if (jump_i) jpc_q <= pc_i;
      end
    end
  end

  assign in_ds_o   = ds_q;
  assign jump_pc_o = jpc_q;

  // R8
  bubble_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!adv_i && !take_i) |=> $stable(ds_q));
endmodule

// File: rtl/trap_epc_reg.sv
module trap_epc_reg #(
  parameter int unsigned AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic          sel_jump_i,
  input  logic [AW-1:0] pc_i,
  input  logic [AW-1:0] jump_pc_i,
  output logic [AW-1:0] epc_o
);
  logic [AW-1:0] epc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   epc_q <= '0;
    else if (we_i) epc_q <= sel_jump_i ? jump_pc_i : pc_i;
  end

  assign epc_o = epc_q;
endmodule

// File: rtl/trap_seq.sv
module trap_seq
  import trap_pkg::*;
#(
  parameter int unsigned   AW       = TRAP_AW,
  parameter logic [AW-1:0] VEC_ADDR = AW'(TRAP_VEC)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          stall_i,
  input  logic          valid_i,
  input  logic          break_i,
  input  logic          syscall_i,
  input  logic          jump_i,
  input  logic [AW-1:0] pc_i,
  output logic          squash_o,
  output logic          redirect_o,
  output logic [AW-1:0] vector_o,
  output logic [AW-1:0] epc_o
);
  logic          take, pend, in_ds;
  logic [AW-1:0] jump_pc;

  trap_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .stall_i    (stall_i),
    .valid_i    (valid_i),
    .trap_req_i (break_i | syscall_i),
    .take_o     (take),
    .pend_o     (pend)
  );

  trap_slot_track #(.AW(AW)) u_slot (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .adv_i     (valid_i & ~stall_i),
    .kill_i    (pend),
    .take_i    (take),
    .jump_i    (jump_i),
    .pc_i      (pc_i),
    .in_ds_o   (in_ds),
    .jump_pc_o (jump_pc)
  );

  trap_epc_reg #(.AW(AW)) u_epc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (take),
    .sel_jump_i (in_ds),
    .pc_i       (pc_i),
    .jump_pc_i  (jump_pc),
    .epc_o      (epc_o)
  );

  assign squash_o   = pend;
  assign redirect_o = pend & ~stall_i;
  assign vector_o   = VEC_ADDR;

  // R5
  redirect_squash_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_o |-> (squash_o && !stall_i));
  // R6
  epc_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_i |=> $stable(epc_o));
  // R3
  ds_epc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && in_ds) |=> (epc_o == $past(jump_pc)));
  // R2
  own_epc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && !in_ds) |=> (epc_o == $past(pc_i)));
  // R4
  squash_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(squash_o) |-> $past(valid_i && (break_i || syscall_i)));
endmodule

// File: tb/tb_trap_seq.sv
module tb_trap_seq;
  localparam int AW = 32;
  localparam logic [AW-1:0] VEC = 32'h3C;

  logic clk = 1'b0, rst_n = 1'b0;
  logic stall = 0, valid = 0, brk = 0, sys = 0, jmp = 0;
  logic [AW-1:0] pc = '0;
  logic squash, redirect;
  logic [AW-1:0] vector, epc;

  int checks = 0, fails = 0;
  bit m_pend = 0, m_ds = 0;
  logic [AW-1:0] m_jpc = '0, m_epc = '0;

  always #4 clk = ~clk;

  trap_seq dut (
    .clk_i(clk), .rst_ni(rst_n), .stall_i(stall), .valid_i(valid),
    .break_i(brk), .syscall_i(sys), .jump_i(jmp), .pc_i(pc),
    .squash_o(squash), .redirect_o(redirect), .vector_o(vector), .epc_o(epc)
  );

  task automatic chk(input string req, input string what,
                     input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // one execute slot: drive at negedge, compare before posedge, advance model
  task automatic cyc(input string req, input bit v, input bit b, input bit s,
                     input bit j, input bit st, input logic [AW-1:0] a);
    bit take;
    valid = v; brk = b; sys = s; jmp = j; stall = st; pc = a;
    #3;
    chk(req, "squash", AW'(squash), AW'(m_pend));
    chk(req, "redirect", AW'(redirect), AW'(m_pend && !st));
    if (redirect) chk(req, "vector", vector, VEC);
    chk(req, "epc", epc, m_epc);
    take = !st && v && (b || s) && !m_pend;
    if (take) begin
      m_epc = m_ds ? m_jpc : a;
      m_ds  = 0;
    end else if (!st && v) begin
      if (m_pend) m_ds = 0;
      else begin
        m_ds = j;
        if (j) m_jpc = a;
      end
    end
    if (!st) m_pend = take;
    @(negedge clk);
  endtask

  initial begin
    #40000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "squash", AW'(squash), '0);
    chk("R1", "redirect", AW'(redirect), '0);
    chk("R1", "epc", epc, '0);
    rst_n = 1'b1;
    @(negedge clk);
    // plain flow with a bubble
    cyc("R8", 1, 0, 0, 0, 0, 32'h100);
    cyc("R8", 0, 0, 0, 0, 0, 32'h0);
    cyc("R8", 1, 0, 0, 0, 0, 32'h104);
    // break in normal position, load behind it
    cyc("R2", 1, 1, 0, 0, 0, 32'h108);
    cyc("R4", 1, 0, 0, 0, 0, 32'h10C);
    chk("R2", "epc own addr", epc, 32'h108);
    cyc("R5", 1, 0, 0, 0, 0, 32'h03C);
    // syscall in a delay slot, jump behind it
    cyc("R3", 1, 0, 0, 1, 0, 32'h200);
    cyc("R7", 1, 0, 1, 0, 0, 32'h204);
    cyc("R4", 1, 0, 0, 1, 0, 32'h208);
    chk("R3", "epc jump addr", epc, 32'h200);
    // killed jump must not mark a delay slot
    cyc("R4", 1, 1, 0, 0, 0, 32'h03C);
    cyc("R4", 1, 0, 0, 0, 0, 32'h040);
    chk("R4", "epc after killed jump", epc, 32'h03C);
    // stall around a waiting trap and the squash slot
    cyc("R6", 1, 0, 1, 0, 1, 32'h300);
    cyc("R6", 1, 0, 1, 0, 1, 32'h300);
    chk("R6", "epc held", epc, 32'h03C);
    cyc("R6", 1, 0, 1, 0, 0, 32'h300);
    cyc("R6", 1, 0, 0, 0, 1, 32'h304);
    cyc("R6", 1, 0, 0, 0, 0, 32'h304);
    chk("R6", "epc after stall", epc, 32'h300);
    // bubble between jump and delay-slot trap
    cyc("R8", 1, 0, 0, 1, 0, 32'h400);
    cyc("R8", 0, 0, 0, 0, 0, 32'h0);
    cyc("R8", 1, 1, 0, 0, 0, 32'h404);
    cyc("R8", 1, 0, 0, 0, 0, 32'h408);
    chk("R8", "epc through bubble", epc, 32'h400);
    // trap behind a trap is killed
    cyc("R7", 1, 0, 1, 0, 0, 32'h500);
    cyc("R4", 1, 1, 0, 0, 0, 32'h504);
    cyc("R4", 1, 0, 0, 0, 0, 32'h03C);
    chk("R4", "killed trap ignored", epc, 32'h500);
    chk("R4", "no second squash", AW'(squash), '0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule